// File: doc/BRIEF.md
# Paged Chip-Select Decoder

This block turns a microcontroller bus access into select lines. An address strobe captures a 16-bit address and one extra high address bit. Each select then comes from an entry held in configuration inputs. An entry has a base value, a care mask, a page value, a page care mask and an enable bit. An entry hits when every cared address bit and every cared page bit equals the base. The decoder drives eight code-memory block selects, one data-RAM select and eleven general chip-select outputs.

A 4-bit page register qualifies every entry. Up to sixteen pages can therefore share one native address range. Software loads the page register by writing to a configured address. A configuration bit chooses where the high address bit comes from: the strobe-captured copy or the live pin. A chip-enable input gates every output. The memory arrays, the pin drivers and the loading of the configuration are outside this block.

Top module: `pcsd_top`

## Requirements
- R1: Synchronous reset (rst_i high at a clock edge) clears the captured address, the captured high bit and the page register to zero. After reset, with csi_i high, only code select 0 can hit for entries that match address 0 on page 0.
- R2: addr_i and hi_i are captured at a clock edge where ale_i is high. While ale_i is low, changes on addr_i do not reach any output.
- R3: Code select i asserts when entry i is enabled, the 17-bit decode address {high bit, captured address} equals base i on every bit set in care i, and the page register equals page i on every bit set in page-care i.
- R4: At most one code select is high. When several code entries hit, only the lowest-indexed one asserts.
- R5: The data-RAM select uses the same match rule with its own single entry.
- R6: Chip-select output j uses the same match rule with entry j. When wrq bit j is set, it also needs wr_i high. When rdq bit j is set, it also needs rd_i high. Both strobes are live, not captured.
- R7: While csi_i is low, every code select, the RAM select and every chip-select output is low.
- R8: With cfg_hi_live_i = 0, the decode high bit is the captured one. With cfg_hi_live_i = 1, the decode high bit is the live hi_i pin.
- R9: At a clock edge where csi_i and wr_i are high and the decode address matches the page-write entry, the page register loads pg_wdata_i. Decoding in that same cycle still uses the old page. The page register holds at every other edge.
- R10: An entry whose enable bit is 0 never drives its select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 16 | Bus address |
| hi_i | input | 1 | Extra high address bit |
| ale_i | input | 1 | Address capture strobe, active high |
| csi_i | input | 1 | Chip enable, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| pg_wdata_i | input | 4 | Value loaded into the page register |
| cfg_hi_live_i | input | 1 | 1: decode high bit follows the live pin |
| cfg_code_base_i | input | 8x17 | Code entry base values |
| cfg_code_care_i | input | 8x17 | Code entry address care masks |
| cfg_code_page_i | input | 8x4 | Code entry page values |
| cfg_code_pcare_i | input | 8x4 | Code entry page care masks |
| cfg_code_en_i | input | 8 | Code entry enables |
| cfg_ram_base_i | input | 17 | RAM entry base |
| cfg_ram_care_i | input | 17 | RAM entry care mask |
| cfg_ram_page_i | input | 4 | RAM entry page value |
| cfg_ram_pcare_i | input | 4 | RAM entry page care mask |
| cfg_ram_en_i | input | 1 | RAM entry enable |
| cfg_cs_base_i | input | 11x17 | Chip-select entry bases |
| cfg_cs_care_i | input | 11x17 | Chip-select entry care masks |
| cfg_cs_page_i | input | 11x4 | Chip-select entry page values |
| cfg_cs_pcare_i | input | 11x4 | Chip-select entry page care masks |
| cfg_cs_en_i | input | 11 | Chip-select entry enables |
| cfg_cs_wrq_i | input | 11 | Per output: also require write strobe |
| cfg_cs_rdq_i | input | 11 | Per output: also require read strobe |
| cfg_pg_base_i | input | 17 | Page-write address |
| cfg_pg_care_i | input | 17 | Page-write address care mask |
| code_sel_o | output | 8 | Code block selects |
| ram_sel_o | output | 1 | Data-RAM select |
| cs_o | output | 11 | General chip-select outputs |

## Verification
A page-register write and the decode of that same bus access fall into one cycle. The bench places a chip-select entry in the page-write address range and qualifies it on the page being written. With the write strobe high, the output must stay low before the clock edge, because decoding still sees the old page. The same output must go high just after the edge, without any new address capture. The bench also sweeps every tested page across a grid of addresses, both high-bit values and three strobe patterns. It compares all twenty outputs against values computed from the configured address ranges.

// File: rtl/pcsd_pkg.sv
package pcsd_pkg;
    localparam int ADDR_W_DEF = 16;
    localparam int PAGE_W_DEF = 4;
    localparam int N_CODE_DEF = 8;
    localparam int N_CS_DEF   = 11;

    typedef enum logic {
        HI_LATCHED = 1'b0,
        HI_LIVE    = 1'b1
    } hi_mode_e;
endpackage

// File: rtl/pcsd_match.sv
module pcsd_match #(
    parameter int N      = 1,
    parameter int FA_W   = 17,
    parameter int PAGE_W = 4
) (
    input  logic [FA_W-1:0]              full_i,
    input  logic [PAGE_W-1:0]            page_i,
    input  logic [N-1:0][FA_W-1:0]       base_i,
    input  logic [N-1:0][FA_W-1:0]       care_i,
    input  logic [N-1:0][PAGE_W-1:0]     pbase_i,
    input  logic [N-1:0][PAGE_W-1:0]     pcare_i,
    input  logic [N-1:0]                 en_i,
    output logic [N-1:0]                 hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_entry
        logic addr_ok;
        logic page_ok;
        assign addr_ok  = ((full_i ^ base_i[g]) & care_i[g]) == '0;
        assign page_ok  = ((page_i ^ pbase_i[g]) & pcare_i[g]) == '0;
        assign hit_o[g] = en_i[g] & addr_ok & page_ok;
    end
endmodule

// File: rtl/pcsd_first.sv
module pcsd_first #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    always_comb begin
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (gnt_o == '0)) begin
                gnt_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcsd_top.sv
module pcsd_top
    import pcsd_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int N_CODE = N_CODE_DEF,
    parameter int N_CS   = N_CS_DEF,
    localparam int FA_W  = ADDR_W + 1
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          hi_i,
    input  logic                          ale_i,
    input  logic                          csi_i,
    input  logic                          rd_i,
    input  logic                          wr_i,
    input  logic [PAGE_W-1:0]             pg_wdata_i,
    input  logic                          cfg_hi_live_i,
    input  logic [N_CODE-1:0][FA_W-1:0]   cfg_code_base_i,
    input  logic [N_CODE-1:0][FA_W-1:0]   cfg_code_care_i,
    input  logic [N_CODE-1:0][PAGE_W-1:0] cfg_code_page_i,
    input  logic [N_CODE-1:0][PAGE_W-1:0] cfg_code_pcare_i,
    input  logic [N_CODE-1:0]             cfg_code_en_i,
    input  logic [FA_W-1:0]               cfg_ram_base_i,
    input  logic [FA_W-1:0]               cfg_ram_care_i,
    input  logic [PAGE_W-1:0]             cfg_ram_page_i,
    input  logic [PAGE_W-1:0]             cfg_ram_pcare_i,
    input  logic                          cfg_ram_en_i,
    input  logic [N_CS-1:0][FA_W-1:0]     cfg_cs_base_i,
    input  logic [N_CS-1:0][FA_W-1:0]     cfg_cs_care_i,
    input  logic [N_CS-1:0][PAGE_W-1:0]   cfg_cs_page_i,
    input  logic [N_CS-1:0][PAGE_W-1:0]   cfg_cs_pcare_i,
    input  logic [N_CS-1:0]               cfg_cs_en_i,
    input  logic [N_CS-1:0]               cfg_cs_wrq_i,
    input  logic [N_CS-1:0]               cfg_cs_rdq_i,
    input  logic [FA_W-1:0]               cfg_pg_base_i,
    input  logic [FA_W-1:0]               cfg_pg_care_i,
    output logic [N_CODE-1:0]             code_sel_o,
    output logic                          ram_sel_o,
    output logic [N_CS-1:0]               cs_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              hi;
        logic [PAGE_W-1:0] page;
    } state_t;

    state_t state_d, state_q;

    hi_mode_e         hi_mode;
    logic             hi_dec;
    logic [FA_W-1:0]  full_addr;
    logic [N_CODE-1:0] code_hit;
    logic [N_CODE-1:0] code_pick;
    logic [0:0]       ram_hit;
    logic [N_CS-1:0]  cs_hit;
    logic [0:0]       pg_hit;
    logic             pg_wr;

    assign hi_mode   = hi_mode_e'(cfg_hi_live_i);
    assign hi_dec    = (hi_mode == HI_LIVE) ? hi_i : state_q.hi;
    assign full_addr = {hi_dec, state_q.addr};

    pcsd_match #(.N(N_CODE), .FA_W(FA_W), .PAGE_W(PAGE_W)) code_match_i (
        .full_i (full_addr),
        .page_i (state_q.page),
        .base_i (cfg_code_base_i),
        .care_i (cfg_code_care_i),
        .pbase_i(cfg_code_page_i),
        .pcare_i(cfg_code_pcare_i),
        .en_i   (cfg_code_en_i),
        .hit_o  (code_hit)
    );

    pcsd_first #(.N(N_CODE)) code_first_i (
        .req_i(code_hit),
        .gnt_o(code_pick)
    );

    pcsd_match #(.N(1), .FA_W(FA_W), .PAGE_W(PAGE_W)) ram_match_i (
        .full_i (full_addr),
        .page_i (state_q.page),
        .base_i (cfg_ram_base_i),
        .care_i (cfg_ram_care_i),
        .pbase_i(cfg_ram_page_i),
        .pcare_i(cfg_ram_pcare_i),
        .en_i   (cfg_ram_en_i),
        .hit_o  (ram_hit)
    );

    pcsd_match #(.N(N_CS), .FA_W(FA_W), .PAGE_W(PAGE_W)) cs_match_i (
        .full_i (full_addr),
        .page_i (state_q.page),
        .base_i (cfg_cs_base_i),
        .care_i (cfg_cs_care_i),
        .pbase_i(cfg_cs_page_i),
        .pcare_i(cfg_cs_pcare_i),
        .en_i   (cfg_cs_en_i),
        .hit_o  (cs_hit)
    );

    pcsd_match #(.N(1), .FA_W(FA_W), .PAGE_W(PAGE_W)) pg_match_i (
        .full_i (full_addr),
        .page_i (state_q.page),
        .base_i (cfg_pg_base_i),
        .care_i (cfg_pg_care_i),
        .pbase_i('0),
        .pcare_i('0),
        .en_i   (1'b1),
        .hit_o  (pg_hit)
    );

    assign pg_wr = csi_i & wr_i & pg_hit[0];

    // Output gating: chip enable plus per-output strobe qualification
    always_comb begin
        code_sel_o = csi_i ? code_pick : '0;
        ram_sel_o  = csi_i & ram_hit[0];
        for (int j = 0; j < N_CS; j++) begin
            cs_o[j] = csi_i & cs_hit[j]
                    & (~cfg_cs_wrq_i[j] | wr_i)
                    & (~cfg_cs_rdq_i[j] | rd_i);
        end
    end

    always_comb begin
        state_d = state_q;
        if (ale_i) begin
            state_d.addr = addr_i;
            state_d.hi   = hi_i;
        end
        if (pg_wr) begin
            state_d.page = pg_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/pcsd_checker.sv
module pcsd_checker #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter int N_CODE = 8,
    parameter int N_CS   = 11
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              ale_i,
    input logic              csi_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [N_CODE-1:0] code_sel_o,
    input logic              ram_sel_o,
    input logic [N_CS-1:0]   cs_o,
    input logic [N_CODE-1:0] cfg_code_en_i,
    input logic [N_CS-1:0]   cfg_cs_wrq_i,
    input logic [N_CS-1:0]   cfg_cs_rdq_i,
    input logic [ADDR_W-1:0] addr_q,
    input logic [PAGE_W-1:0] page_q
);
    assert_reset_page_R1: assert property (@(posedge clk_i)
        rst_i |=> (page_q == '0));

    assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !ale_i |=> $stable(addr_q));

    assert_code_onehot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(code_sel_o));

    assert_strobe_qual_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ((cs_o & cfg_cs_wrq_i & {N_CS{~wr_i}}) == '0) &&
        ((cs_o & cfg_cs_rdq_i & {N_CS{~rd_i}}) == '0));

    assert_csi_gate_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !csi_i |-> (code_sel_o == '0) && !ram_sel_o && (cs_o == '0));

    assert_page_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_i |=> $stable(page_q));

    assert_disabled_quiet_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (code_sel_o & ~cfg_code_en_i) == '0);
endmodule

bind pcsd_top pcsd_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .N_CODE(N_CODE), .N_CS(N_CS)
) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .ale_i        (ale_i),
    .csi_i        (csi_i),
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .code_sel_o   (code_sel_o),
    .ram_sel_o    (ram_sel_o),
    .cs_o         (cs_o),
    .cfg_code_en_i(cfg_code_en_i),
    .cfg_cs_wrq_i (cfg_cs_wrq_i),
    .cfg_cs_rdq_i (cfg_cs_rdq_i),
    .addr_q       (state_q.addr),
    .page_q       (state_q.page)
);

// File: tb/pcsd_top_tb_top.sv
module pcsd_top_tb_top;
    localparam int AW = 16;
    localparam int PW = 4;
    localparam int NC = 8;
    localparam int NS = 11;
    localparam int FW = AW + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, hi, ale, csi, rd, wr, hi_live;
    logic [AW-1:0] addr;
    logic [PW-1:0] pg_wdata;
    logic [NC-1:0][FW-1:0] c_base, c_care;
    logic [NC-1:0][PW-1:0] c_page, c_pcare;
    logic [NC-1:0]         c_en;
    logic [FW-1:0] r_base, r_care, p_base, p_care;
    logic [PW-1:0] r_page, r_pcare;
    logic          r_en;
    logic [NS-1:0][FW-1:0] s_base, s_care;
    logic [NS-1:0][PW-1:0] s_page, s_pcare;
    logic [NS-1:0]         s_en, s_wrq, s_rdq;
    logic [NC-1:0] code_sel;
    logic          ram_sel;
    logic [NS-1:0] cs;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    pcsd_top dut_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .hi_i(hi), .ale_i(ale),
        .csi_i(csi), .rd_i(rd), .wr_i(wr), .pg_wdata_i(pg_wdata),
        .cfg_hi_live_i(hi_live),
        .cfg_code_base_i(c_base), .cfg_code_care_i(c_care),
        .cfg_code_page_i(c_page), .cfg_code_pcare_i(c_pcare), .cfg_code_en_i(c_en),
        .cfg_ram_base_i(r_base), .cfg_ram_care_i(r_care),
        .cfg_ram_page_i(r_page), .cfg_ram_pcare_i(r_pcare), .cfg_ram_en_i(r_en),
        .cfg_cs_base_i(s_base), .cfg_cs_care_i(s_care),
        .cfg_cs_page_i(s_page), .cfg_cs_pcare_i(s_pcare), .cfg_cs_en_i(s_en),
        .cfg_cs_wrq_i(s_wrq), .cfg_cs_rdq_i(s_rdq),
        .cfg_pg_base_i(p_base), .cfg_pg_care_i(p_care),
        .code_sel_o(code_sel), .ram_sel_o(ram_sel), .cs_o(cs)
    );

    // Expected values from the address map the bench configures
    function automatic logic [NC-1:0] exp_code(logic [AW-1:0] a, logic h, logic [PW-1:0] p);
        int b = int'(a[15:13]);
        exp_code = '0;
        if (h) return '0;
        if (b == 5) return '0;                 // entry 5 disabled
        if (b == 3 && p != 4'd2) return '0;    // entry 3 on page 2 only
        if (b == 7) b = 6;                     // entry 6 wider, outranks 7
        exp_code[b] = 1'b1;
    endfunction

    function automatic logic exp_ram(logic [AW-1:0] a, logic h);
        return h && (a < 16'h0800);
    endfunction

    function automatic logic [NS-1:0] exp_cs(logic [AW-1:0] a, logic h, logic [PW-1:0] p,
                                             logic r, logic w);
        for (int j = 0; j < NS; j++) begin
            logic e;
            e = h && (int'(a[15:12]) == j + 5);
            if (j == 10)      e = e && (p == 4'd3);
            else if (j % 2)   e = e && (p == 4'd1);
            if (j == 0 || j == 4) e = e && w;
            if (j == 2)       e = e && r;
            exp_cs[j] = e;
        end
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic outs_check(string req, logic [AW-1:0] a, logic h, logic [PW-1:0] p);
        check(req, {12'd0, code_sel, ram_sel, cs},
              {12'd0, exp_code(a, h, p), exp_ram(a, h), exp_cs(a, h, p, rd, wr)});
    endtask

    task automatic capture(logic [AW-1:0] a, logic h);
        @(negedge clk);
        addr = a; hi = h; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0;
        #1;
    endtask

    task automatic set_page(logic [PW-1:0] p);
        capture(16'hFFF0, 1'b1);
        wr = 1'b1; pg_wdata = p;
        @(negedge clk);
        wr = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; hi = 0; ale = 0; csi = 1; rd = 0; wr = 0; hi_live = 0;
        addr = '0; pg_wdata = '0;
        for (int i = 0; i < NC; i++) begin
            c_base[i] = {1'b0, 3'(i), 13'd0};
            c_care[i] = (i == 6) ? 17'h1C000 : 17'h1E000;
            c_page[i] = (i == 3) ? 4'd2 : 4'd0;
            c_pcare[i] = (i == 3) ? 4'hF : 4'h0;
            c_en[i] = (i != 5);
        end
        r_base = 17'h10000; r_care = 17'h1F800; r_page = '0; r_pcare = '0; r_en = 1'b1;
        for (int j = 0; j < NS; j++) begin
            s_base[j]  = {1'b1, 4'(j + 5), 12'd0};
            s_care[j]  = 17'h1F000;
            s_page[j]  = (j == 10) ? 4'd3 : ((j % 2) ? 4'd1 : 4'd0);
            s_pcare[j] = ((j == 10) || (j % 2)) ? 4'hF : 4'h0;
            s_en[j]    = 1'b1;
            s_wrq[j]   = (j == 0 || j == 4);
            s_rdq[j]   = (j == 2);
        end
        p_base = 17'h1FFF0; p_care = 17'h1FFFF;
        do_reset();

        // R1: address and page cleared, code 0 hits at address 0
        check("R1 reset outputs", {12'd0, code_sel, ram_sel, cs}, {12'd0, 8'h01, 1'b0, 11'd0});

        // R3 R4 R5 R6 R10: sweep pages, addresses, high bit and strobes
        for (int pi = 0; pi < 4; pi++) begin
            set_page(4'(pi));
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k < 64; k++) begin
                    logic [AW-1:0] a;
                    a = 16'(k * 16'h0400 + 16'h0155);
                    capture(a, 1'(h));
                    rd = 0; wr = 0; #1;
                    outs_check("R3/R4/R5/R6/R10 sweep idle", a, 1'(h), 4'(pi));
                    rd = 1; #1;
                    outs_check("R6 sweep read", a, 1'(h), 4'(pi));
                    rd = 0; wr = 1; #1;
                    outs_check("R6 sweep write", a, 1'(h), 4'(pi));
                    wr = 0; #1;
                end
            end
        end

        // R4: overlapping entries 6 and 7, lowest wins
        capture(16'hE000, 1'b0);
        check("R4 overlap priority", {24'd0, code_sel}, {24'd0, 8'h40});

        // R2: address change without strobe is ignored
        capture(16'h0155, 1'b0);
        @(negedge clk); addr = 16'h4155; #1;
        @(negedge clk); #1;
        check("R2 hold without strobe", {24'd0, code_sel}, {24'd0, 8'h01});

        // R8: latched versus live high bit
        hi = 1'b1; #1;
        check("R8 latched high bit", {23'd0, code_sel, ram_sel}, {23'd0, 8'h01, 1'b0});
        hi_live = 1'b1; #1;
        check("R8 live high bit", {23'd0, code_sel, ram_sel}, {23'd0, 8'h00, 1'b1});
        hi = 1'b0; #1;
        check("R8 live high bit low", {23'd0, code_sel, ram_sel}, {23'd0, 8'h01, 1'b0});
        hi_live = 1'b0;

        // R7: chip enable low gates everything
        capture(16'h6000, 1'b1);
        set_page(4'd1);
        capture(16'h6000, 1'b1);
        check("R7 enabled reference", {21'd0, cs}, {21'd0, 11'h002});
        csi = 1'b0; #1;
        check("R7 gated outputs", {12'd0, code_sel, ram_sel, cs}, 32'd0);
        capture(16'h0155, 1'b0);
        check("R7 gated code", {24'd0, code_sel}, 32'd0);
        csi = 1'b1;

        // R9: write with csi low does not load the page
        capture(16'hFFF0, 1'b1);
        csi = 1'b0; wr = 1'b1; pg_wdata = 4'd3;
        @(negedge clk); wr = 1'b0; csi = 1'b1; #1;
        capture(16'h6000, 1'b1);
        check("R9 no load when disabled", {21'd0, cs}, {21'd0, 11'h002});

        // R9: page write and decode in the same cycle (cs10 sits at FFF0)
        set_page(4'd0);
        capture(16'hFFF0, 1'b1);
        wr = 1'b1; pg_wdata = 4'd3; #1;
        check("R9 old page before edge", {31'd0, cs[10]}, 32'd0);
        @(posedge clk); #1;
        check("R9 new page after edge", {31'd0, cs[10]}, 32'd1);
        @(negedge clk); wr = 1'b0; #1;

        // R1: reset clears a loaded page
        set_page(4'd1);
        do_reset();
        capture(16'h6000, 1'b1);
        check("R1 page cleared", {21'd0, cs}, 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule